// File: doc/BRIEF.md
# Dual Program Stack Pointer Controller

This block owns the stack pointers of a small processor core. It keeps three pointers: a supervisor program pointer, a user program pointer and an interrupt pointer. It also keeps the flag that says whether the core runs in user mode. Decoded operation strobes arrive on a valid/ready operation port. The block turns each operation into pointer updates, a mode change, or one or two beats on a valid/ready memory port that carries one 16-bit word per beat.

All stacks grow toward lower addresses. A push writes to the pointer minus 2 and keeps that address as the new pointer. A pop reads at the pointer and then adds 2. The mode flag chooses which program pointer serves push, pop and pop-return. Exceptions always use the interrupt pointer.

User mode can be entered only in two ways: the dedicated user jump, or an exception return that restores a saved flag. Taking an exception leaves user mode. Processor-register writes are refused in user mode.

Back-pressure rules:
- An operation is taken in a cycle where `op_valid` and `op_ready` are both high. The caller holds its inputs stable until then.
- An operation that touches memory is taken only in a cycle where `mem_ready` is high.
- While `mem_valid` is high and `mem_ready` is low, the block holds the address, the write enable and the write data stable.
- Read data on `mem_rdata` is sampled in the cycle where `mem_ready` is high.

Top module: `stack_ptr_ctrl`

## Requirements
- R1: A push (code 0) makes one write beat at active pointer minus 2, with `op_data[15:0]` as data, and that address becomes the pointer. A pop (code 1) makes one read beat at the active pointer, which then grows by 2.
- R2: While `user_mode` is low, push, pop and pop-return use the supervisor pointer.
- R3: While `user_mode` is high, push, pop and pop-return use the user pointer.
- R4: The user jump (code 3) takes no memory beat. In the cycle it is taken it raises `jump_valid` with `jump_addr = op_data[15:0]`, and `user_mode` is high from the next cycle. Apart from this, only an exception return can raise `user_mode`.
- R5: Exception entry (code 4) writes two beats. The first goes to interrupt pointer minus 2 and carries `op_data[15:0]`. The second goes to interrupt pointer minus 4 and carries the status word `{status_in, user_mode}`, with the mode flag in bit 0. The interrupt pointer then drops by 4, and `user_mode` is low after the second beat.
- R6: Exception return (code 5) reads the interrupt pointer first, and bit 0 of that word becomes `user_mode`. It then reads interrupt pointer plus 2 and gives that word on `jump_addr` with `jump_valid`, in the cycle of that beat. The interrupt pointer then grows by 4.
- R7: A processor-register write (code 6) taken in user mode raises `viol` for exactly the following cycle and changes no pointer and no mode. Taken in supervisor mode, `op_sel` 0, 1 and 2 load the supervisor, user or interrupt pointer with `op_data`, and `op_sel` 3 changes nothing.
- R8: Pop-return (code 2) behaves as a pop and also raises `jump_valid` with `jump_addr` equal to the word read, in the cycle of the beat.
- R9: Memory operations are taken only in a cycle with `mem_ready` high. During the second beat of exception entry or return, `op_ready` stays low and the request is held stable until `mem_ready`.
- R10: After reset `user_mode`, `viol` and `mem_valid` are low, and the pointers hold the parameter reset values.
- R11: Code 7 is taken at once and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Operation taken this cycle |
| op_code | input | 3 | Operation code (0 push, 1 pop, 2 pop-return, 3 user jump, 4 exception entry, 5 exception return, 6 register write, 7 none) |
| op_data | input | 32 | Push data, jump target, return address or register value |
| op_sel | input | 2 | Register-write target (0 supervisor, 1 user, 2 interrupt, 3 none) |
| status_in | input | 15 | Status bits saved above the mode flag on exception entry |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 16 | Read word, valid with mem_ready |
| jump_valid | output | 1 | Jump target presented this cycle |
| jump_addr | output | 16 | Jump target |
| user_mode | output | 1 | User-mode flag |
| viol | output | 1 | Refused privileged write, one-cycle pulse |

## Verification
A wrong pointer shows up on `mem_addr` at the next push or pop that uses it. For the interrupt pointer, that is the next exception entry or return. A wrong mode flag shows up on `user_mode` one cycle after the operation, and also as a push to the wrong stack. A bad status word or a bad restore shows up only when the matching exception return reads it back, so the random mix nests exceptions and pops and follows every store to its later read.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [2:0] {
    OP_PUSH   = 3'd0,
    OP_POP    = 3'd1,
    OP_POPRET = 3'd2,
    OP_JUSR   = 3'd3,
    OP_EXC    = 3'd4,
    OP_ERET   = 3'd5,
    OP_PRWR   = 3'd6,
    OP_NONE   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXC2  = 2'd1,
    ST_ERET2 = 2'd2
  } seq_e;

  localparam int NPTR   = 3;
  localparam int IX_SSP = 0;
  localparam int IX_USP = 1;
  localparam int IX_ISP = 2;
endpackage

// File: rtl/spc_bank.sv
module spc_bank #(
  parameter int PTR_W = 32,
  parameter int NPTR  = 3,
  parameter logic [NPTR*PTR_W-1:0] RST_VALS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPTR-1:0]       ld_en,
  input  logic [NPTR*PTR_W-1:0] ld_val,
  output logic [NPTR*PTR_W-1:0] ptrs
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [PTR_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= RST_VALS[g*PTR_W +: PTR_W];
      else if (ld_en[g]) q <= ld_val[g*PTR_W +: PTR_W];
    end
    assign ptrs[g*PTR_W +: PTR_W] = q;
  end
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
#(
  parameter int PTR_W  = 32,
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  output logic                  op_ready,
  input  logic [2:0]            op_code,
  input  logic [PTR_W-1:0]      op_data,
  input  logic [1:0]            op_sel,
  input  logic [WORD_W-2:0]     status_in,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic                  mem_we,
  output logic [PTR_W-1:0]      mem_addr,
  output logic [WORD_W-1:0]     mem_wdata,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic                  jump_valid,
  output logic [WORD_W-1:0]     jump_addr,
  output logic                  user_mode,
  output logic                  viol,
  input  logic [NPTR*PTR_W-1:0] ptrs,
  output logic [NPTR-1:0]       ld_en,
  output logic [NPTR*PTR_W-1:0] ld_val
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(WORD_W / 8);

  logic [PTR_W-1:0] ssp, usp, isp, act_sp;
  logic [1:0]       act_ix;
  assign ssp = ptrs[IX_SSP*PTR_W +: PTR_W];
  assign usp = ptrs[IX_USP*PTR_W +: PTR_W];
  assign isp = ptrs[IX_ISP*PTR_W +: PTR_W];

  logic             user_q, user_nxt, viol_q, viol_nxt, stat_ld;
  seq_e             state_q, state_nxt;
  logic [WORD_W-1:0] stat_q;
  logic [1:0]       ld_ix;
  logic             ld_any;
  logic [PTR_W-1:0] ld_v;
  op_e              op;

  assign op     = op_e'(op_code);
  assign act_sp = user_q ? usp : ssp;
  assign act_ix = user_q ? 2'(IX_USP) : 2'(IX_SSP);

  always_comb begin
    op_ready   = 1'b0;
    mem_valid  = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = '0;
    jump_valid = 1'b0;
    jump_addr  = '0;
    ld_any     = 1'b0;
    ld_ix      = 2'(IX_SSP);
    ld_v       = '0;
    user_nxt   = user_q;
    viol_nxt   = 1'b0;
    stat_ld    = 1'b0;
    state_nxt  = state_q;
    case (state_q)
      ST_IDLE: if (op_valid) begin
        case (op)
          OP_PUSH: begin
            mem_valid = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = act_sp - STEP;
            mem_wdata = op_data[WORD_W-1:0];
            op_ready  = mem_ready;
            ld_any    = mem_ready;
            ld_ix     = act_ix;
            ld_v      = act_sp - STEP;
          end
          OP_POP, OP_POPRET: begin
            mem_valid  = 1'b1;
            mem_addr   = act_sp;
            op_ready   = mem_ready;
            ld_any     = mem_ready;
            ld_ix      = act_ix;
            ld_v       = act_sp + STEP;
            jump_valid = (op == OP_POPRET) && mem_ready;
            jump_addr  = mem_rdata;
          end
          OP_JUSR: begin
            op_ready   = 1'b1;
            jump_valid = 1'b1;
            jump_addr  = op_data[WORD_W-1:0];
            user_nxt   = 1'b1;
          end
          OP_EXC: begin
            mem_valid = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = isp - STEP;
            mem_wdata = op_data[WORD_W-1:0];
            op_ready  = mem_ready;
            ld_any    = mem_ready;
            ld_ix     = 2'(IX_ISP);
            ld_v      = isp - STEP;
            stat_ld   = mem_ready;
            if (mem_ready) state_nxt = ST_EXC2;
          end
          OP_ERET: begin
            mem_valid = 1'b1;
            mem_addr  = isp;
            op_ready  = mem_ready;
            ld_any    = mem_ready;
            ld_ix     = 2'(IX_ISP);
            ld_v      = isp + STEP;
            if (mem_ready) begin
              user_nxt  = mem_rdata[0];
              state_nxt = ST_ERET2;
            end
          end
          OP_PRWR: begin
            op_ready = 1'b1;
            viol_nxt = user_q;
            ld_any   = !user_q && (op_sel != 2'd3);
            ld_ix    = op_sel;
            ld_v     = op_data;
          end
          default: op_ready = 1'b1;
        endcase
      end
      ST_EXC2: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = isp - STEP;
        mem_wdata = stat_q;
        ld_any    = mem_ready;
        ld_ix     = 2'(IX_ISP);
        ld_v      = isp - STEP;
        if (mem_ready) begin
          user_nxt  = 1'b0;
          state_nxt = ST_IDLE;
        end
      end
      ST_ERET2: begin
        mem_valid  = 1'b1;
        mem_addr   = isp;
        ld_any     = mem_ready;
        ld_ix      = 2'(IX_ISP);
        ld_v       = isp + STEP;
        jump_valid = mem_ready;
        jump_addr  = mem_rdata;
        if (mem_ready) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  assign ld_en  = ld_any ? (NPTR'(1) << ld_ix) : '0;
  assign ld_val = {NPTR{ld_v}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      user_q  <= 1'b0;
      viol_q  <= 1'b0;
      stat_q  <= '0;
    end else begin
      state_q <= state_nxt;
      user_q  <= user_nxt;
      viol_q  <= viol_nxt;
      if (stat_ld) stat_q <= {status_in, user_q};
    end
  end

  assign user_mode = user_q;
  assign viol      = viol_q;

  logic acc;
  assign acc = op_valid && op_ready;

  AST_USER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(user_q) |-> $past(acc && (op == OP_JUSR || op == OP_ERET))); // R4
  AST_JUMP_SETS_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_JUSR && state_q == ST_IDLE) |=> user_q); // R4
  AST_EXC_DROPS_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXC2 && mem_ready) |=> !user_q); // R5
  AST_VIOL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> (ptrs == $past(ptrs) && user_q == $past(user_q))); // R7
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && state_q != ST_IDLE) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_SECOND_BEAT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !op_ready); // R9
endmodule

// File: rtl/stack_ptr_ctrl.sv
module stack_ptr_ctrl
  import spc_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int WORD_W = 16,
  parameter logic [PTR_W-1:0] SSP_RST = 32'h0000_0800,
  parameter logic [PTR_W-1:0] USP_RST = 32'h0000_0600,
  parameter logic [PTR_W-1:0] ISP_RST = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_code,
  input  logic [PTR_W-1:0]  op_data,
  input  logic [1:0]        op_sel,
  input  logic [WORD_W-2:0] status_in,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              jump_valid,
  output logic [WORD_W-1:0] jump_addr,
  output logic              user_mode,
  output logic              viol
);
  localparam logic [NPTR*PTR_W-1:0] RST_VALS = {ISP_RST, USP_RST, SSP_RST};

  logic [NPTR*PTR_W-1:0] ptrs, ld_val;
  logic [NPTR-1:0]       ld_en;

  spc_bank #(.PTR_W(PTR_W), .NPTR(NPTR), .RST_VALS(RST_VALS)) u_bank (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val), .ptrs(ptrs)
  );

  spc_ctrl #(.PTR_W(PTR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
    .op_data(op_data), .op_sel(op_sel), .status_in(status_in),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .jump_valid(jump_valid), .jump_addr(jump_addr),
    .user_mode(user_mode), .viol(viol),
    .ptrs(ptrs), .ld_en(ld_en), .ld_val(ld_val)
  );
endmodule

// File: tb/stack_ptr_ctrl_test.sv
module stack_ptr_ctrl_test;
  localparam logic [31:0] SSP0 = 32'h0000_0800;
  localparam logic [31:0] USP0 = 32'h0000_0600;
  localparam logic [31:0] ISP0 = 32'h0000_0400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_ready;
  logic [2:0] op_code = '0;
  logic [31:0] op_data = '0;
  logic [1:0] op_sel = '0;
  logic [14:0] status_in = '0;
  logic mem_valid, mem_ready = 1'b0, mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic jump_valid, user_mode, viol;
  logic [15:0] jump_addr;

  stack_ptr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_data(op_data), .op_sel(op_sel), .status_in(status_in),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .jump_valid(jump_valid), .jump_addr(jump_addr), .user_mode(user_mode), .viol(viol)
  );

  always #10 clk = ~clk;

  logic [15:0] bmem [1024];
  assign mem_rdata = bmem[mem_addr[10:1]];
  always @(posedge clk) if (mem_valid && mem_ready && mem_we) bmem[mem_addr[10:1]] <= mem_wdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] m_ssp = SSP0, m_usp = USP0, m_isp = ISP0;
  bit m_user = 1'b0;

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] act_sp();
    return m_user ? m_usp : m_ssp;
  endfunction

  function automatic string mode_tag();
    return m_user ? "R3 user stack" : "R2 supervisor stack";
  endfunction

  task automatic do_beat(input bit we, input logic [31:0] addr, input logic [15:0] wd,
                         input string req, output logic [15:0] rd, output bit jv,
                         output logic [15:0] ja, output bit ordy);
    forever begin
      mem_ready = ($urandom_range(3) != 0);
      #1;
      if (!mem_ready) begin
        chk_eq({req, " R9 stall"}, {31'd0, op_ready}, 32'd0);
        @(negedge clk);
        continue;
      end
      chk_eq({req, " addr"}, mem_addr, addr);
      chk_eq({req, " kind"}, {30'd0, mem_valid, mem_we}, {30'd0, 1'b1, we});
      if (we) chk_eq({req, " wdata"}, {16'd0, mem_wdata}, {16'd0, wd});
      rd = mem_rdata; jv = jump_valid; ja = jump_addr; ordy = op_ready;
      break;
    end
  endtask

  task automatic run_op(input logic [2:0] code, input logic [31:0] data,
                        input logic [1:0] sel, input logic [14:0] stat);
    logic [15:0] rd, ja, ex;
    logic [31:0] a;
    bit jv, ordy, exp_viol;
    exp_viol = 1'b0;
    op_code = code; op_data = data; op_sel = sel; status_in = stat; op_valid = 1'b1;
    case (code)
      3'd0: begin
        a = act_sp() - 32'd2;
        do_beat(1'b1, a, data[15:0], {"R1 push ", mode_tag()}, rd, jv, ja, ordy);
        chk_eq("R9 push taken", {31'd0, ordy}, 32'd1);
        if (m_user) m_usp = a; else m_ssp = a;
      end
      3'd1, 3'd2: begin
        a = act_sp();
        ex = bmem[a[10:1]];
        do_beat(1'b0, a, 16'd0, {"R1 pop ", mode_tag()}, rd, jv, ja, ordy);
        chk_eq("R9 pop taken", {31'd0, ordy}, 32'd1);
        if (code == 3'd2) chk_eq("R8 pop-return jump", {15'd0, jv, ja}, {15'd0, 1'b1, ex});
        else chk_eq("R1 pop no jump", {31'd0, jv}, 32'd0);
        if (m_user) m_usp = a + 32'd2; else m_ssp = a + 32'd2;
      end
      3'd3: begin
        mem_ready = $urandom_range(1);
        #1;
        chk_eq("R4 user jump", {14'd0, op_ready, mem_valid, jump_valid, jump_addr},
               {14'd0, 1'b1, 1'b0, 1'b1, data[15:0]});
        m_user = 1'b1;
      end
      3'd4: begin
        do_beat(1'b1, m_isp - 32'd2, data[15:0], "R5 exc return addr", rd, jv, ja, ordy);
        chk_eq("R9 exc first beat taken", {31'd0, ordy}, 32'd1);
        @(negedge clk);
        do_beat(1'b1, m_isp - 32'd4, {stat, m_user}, "R5 exc status", rd, jv, ja, ordy);
        chk_eq("R9 exc second beat busy", {31'd0, ordy}, 32'd0);
        m_isp = m_isp - 32'd4;
        m_user = 1'b0;
      end
      3'd5: begin
        ex = bmem[m_isp[10:1]];
        do_beat(1'b0, m_isp, 16'd0, "R6 eret status", rd, jv, ja, ordy);
        chk_eq("R9 eret first beat taken", {31'd0, ordy}, 32'd1);
        m_user = ex[0];
        a = m_isp + 32'd2;
        ex = bmem[a[10:1]];
        @(negedge clk);
        do_beat(1'b0, a, 16'd0, "R6 eret addr", rd, jv, ja, ordy);
        chk_eq("R6 eret jump", {14'd0, ordy, jv, ja}, {14'd0, 1'b0, 1'b1, ex});
        m_isp = m_isp + 32'd4;
      end
      3'd6: begin
        mem_ready = $urandom_range(1);
        #1;
        chk_eq("R7 reg write taken", {30'd0, op_ready, mem_valid}, {30'd0, 1'b1, 1'b0});
        if (m_user) exp_viol = 1'b1;
        else case (sel)
          2'd0: m_ssp = data;
          2'd1: m_usp = data;
          2'd2: m_isp = data;
          default: ;
        endcase
      end
      default: begin
        mem_ready = $urandom_range(1);
        #1;
        chk_eq("R11 code 7 taken idle", {30'd0, op_ready, mem_valid}, {30'd0, 1'b1, 1'b0});
      end
    endcase
    @(negedge clk);
    op_valid = 1'b0; mem_ready = 1'b0;
    #1;
    chk_eq("R7 viol pulse", {31'd0, viol}, {31'd0, exp_viol});
    chk_eq("R4 R5 R6 mode flag", {31'd0, user_mode}, {31'd0, m_user});
  endtask

  function automatic logic [31:0] rnd_ptr();
    return 32'h100 + ({$urandom_range(32'h600)} & 32'hFFFF_FFFE);
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 16'(i * 37 + 5);
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk_eq("R10 reset state", {29'd0, user_mode, viol, mem_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    op_code = 3'd1; op_valid = 1'b1; mem_ready = 1'b0;
    #1;
    chk_eq("R10 supervisor pointer reset value", mem_addr, SSP0);
    op_code = 3'd4; op_data = 32'h1234;
    #1;
    chk_eq("R10 interrupt pointer reset value", mem_addr, ISP0 - 32'd2);
    op_valid = 1'b0;
    @(negedge clk);
    // directed corners
    run_op(3'd0, 32'hA5A5, 2'd0, 15'd0);
    run_op(3'd3, 32'h0042, 2'd0, 15'd0);
    run_op(3'd0, 32'h5A5A, 2'd0, 15'd0);
    run_op(3'd6, 32'h0000_0222, 2'd0, 15'd0);
    run_op(3'd6, 32'h0000_0222, 2'd2, 15'd0);
    run_op(3'd0, 32'h1111, 2'd0, 15'd0);
    run_op(3'd4, 32'h0777, 2'd0, 15'h2AAA);
    run_op(3'd0, 32'h2222, 2'd0, 15'd0);
    run_op(3'd1, 32'd0, 2'd0, 15'd0);
    run_op(3'd5, 32'd0, 2'd0, 15'd0);
    run_op(3'd2, 32'd0, 2'd0, 15'd0);
    run_op(3'd7, 32'd0, 2'd0, 15'd0);
    run_op(3'd1, 32'd0, 2'd0, 15'd0);
    run_op(3'd4, 32'h0888, 2'd0, 15'h1555);
    run_op(3'd6, 32'h0000_0300, 2'd1, 15'd0);
    run_op(3'd6, 32'h0000_0500, 2'd3, 15'd0);
    run_op(3'd3, 32'h0099, 2'd0, 15'd0);
    run_op(3'd0, 32'h3333, 2'd0, 15'd0);
    // constrained random mix
    for (int k = 0; k < 500; k++) begin
      logic [2:0] c;
      c = 3'($urandom_range(7));
      run_op(c, (c == 3'd6) ? rnd_ptr() : {16'd0, 16'($urandom)},
             2'($urandom_range(3)), 15'($urandom));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule